// File: doc/BRIEF.md
# Multi-channel millisecond input debouncer

This block filters up to eight slow external input lines, such as buttons, lid switches and card-detect contacts. It reports each line's level only after the level has held steady for a programmable number of milliseconds. It runs on a fast system clock. A one-cycle strobe `ms_tick` arrives once per millisecond and sets the time base. Every line passes through a two-flop synchronizer. A small per-channel state machine then decides when a new level has settled. When a settled level matches the channel's selected polarity, the block latches a sticky pending flag. The enabled pending flags are ORed into one active-high interrupt.

Each channel state machine has four states. The states are `ST_OFF` (channel disabled, level frozen), `ST_IDLE` (synchronized input equals the accepted level), `ST_ALIGN` (input differs and the machine waits for the next tick so that a full millisecond is measured) and `ST_COUNT` (counting whole milliseconds). The transitions are named as follows:
- *enable* takes OFF to IDLE.
- *disable* takes any state to OFF.
- *mismatch* takes IDLE to ALIGN.
- *first tick* takes ALIGN to COUNT.
- *revert* takes ALIGN or COUNT to IDLE when the input returns to the accepted level.
- *accept* takes COUNT to IDLE on the tick that completes the window. It updates the level and may set pending.

The output `cnt_clk_en` requests the millisecond time base only while some enabled channel sees a mismatch. The tick reaching the channels is gated by it. Software programs the block through a simple word-wide write/read port.

Top module: `msdb_top`

## Requirements
- R1: After reset, `level_o`, `irq` and `cnt_clk_en` are 0. The enable, polarity and pending registers read 0, and every length register reads 1.
- R2: A change held continuously is accepted only after eff_len+1 ticks have been seen while the synchronized input differs. The first of those ticks aligns, and each later tick counts 1 ms. The level therefore moves no earlier than eff_len*T and no later than (eff_len+1)*T+5 cycles after the pin changes, where T is the tick period in cycles.
- R3: A pulse shorter than one tick period causes no level change and no pending bit. If the input returns to the accepted level, the count is discarded, and a later change must hold for a full new window.
- R4: Length value 0 acts as 1 ms. Values above 4000 act as 4000 ms. The register still reads back the raw written value.
- R5: Pending bit i is set when channel i accepts a new level equal to polarity bit i. Bit value 1 selects rising, and bit value 0 selects falling. An accept of the other direction sets nothing.
- R6: Pending bits are sticky across later accepts. Writing 1 to a bit of the pending register (address 2) clears that bit and re-arms it. Writing 0 leaves the bit unchanged, and a re-armed channel sets its bit again on its next matching accept.
- R7: `irq` is the OR of the pending bits whose enable bit is 1. Clearing an enable bit masks that channel's pending bit from `irq` without clearing it.
- R8: While its enable bit is 0, a channel ignores its input: its level, its pending bit and `cnt_clk_en` are unaffected. When the channel is enabled, a differing input starts a normal debounce window.
- R9: `cnt_clk_en` is 1 exactly while some enabled channel's synchronized input differs from its accepted level, and 0 once all match.
- R10: The registers are laid out as follows. The enable mask is at address 0, the polarity mask at 1, the pending register at 2, and the accepted levels (read-only) at 3. The length of channel i is at address 8+i, in bits [11:0]. Registers at 0, 1 and 8+i read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| in_pins | input | 8 | Raw asynchronous input lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| level_o | output | 8 | Accepted debounced levels |
| irq | output | 1 | Shared level-high interrupt |
| cnt_clk_en | output | 1 | Request for the millisecond counting clock |

## Verification
A channel machine stuck in the wrong state shows up at `level_o` in one of two ways. The level moves outside the window bounded by eff_len*T and (eff_len+1)*T+5 cycles, or it moves for a glitch. The scoreboard flags either within one debounce window. A miscounted or unclamped length shows up as a level change outside that window. This is visible even at the 4000 ms clamp, because an unclamped 4095 misses the upper bound by 95 ticks. Wrong pending or mask state appears as a wrong `irq` or pending readback within one cycle of the accept or of the register write. A wrong mismatch term appears on `cnt_clk_en` within three cycles of a pin change.

// File: rtl/msdb_pkg.sv
package msdb_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ALIGN = 2'd2,
        ST_COUNT = 2'd3
    } chan_state_e;

    localparam int unsigned REG_EN   = 0;
    localparam int unsigned REG_POL  = 1;
    localparam int unsigned REG_PEND = 2;
    localparam int unsigned REG_LVL  = 3;
    localparam int unsigned REG_LEN0 = 8;

endpackage

// File: rtl/msdb_sync.sv
module msdb_sync #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    logic [N-1:0] stage1_q;
    logic [N-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/msdb_chan.sv
module msdb_chan
    import msdb_pkg::*;
#(
    parameter int CW     = 12,
    parameter int MAX_MS = 4000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic          in_i,
    input  logic [CW-1:0] len_i,
    output logic          level_o,
    output logic          accept_o,
    output logic          busy_o
);

    localparam logic [CW-1:0] LEN_MAX = CW'(MAX_MS);
    localparam logic [CW-1:0] LEN_ONE = CW'(1);

    chan_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] eff_len;
    logic          level_q;
    logic          differ;
    logic          last_ms;

    // Length clamp: 0 acts as 1, above the ceiling acts as the ceiling.
    always_comb begin
        if (len_i == '0)
            eff_len = LEN_ONE;
        else if (len_i > LEN_MAX)
            eff_len = LEN_MAX;
        else
            eff_len = len_i;
    end

    assign differ  = in_i ^ level_q;
    assign last_ms = (cnt_q + LEN_ONE) >= eff_len;

    // Output process
    always_comb begin
        accept_o = (state_q == ST_COUNT) && en_i && differ && tick_i && last_ms;
        busy_o   = en_i && differ;
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_i) state_d = ST_IDLE;              // enable
            end
            ST_IDLE: begin
                if (!en_i)       state_d = ST_OFF;        // disable
                else if (differ) state_d = ST_ALIGN;      // mismatch
            end
            ST_ALIGN: begin
                if (!en_i)        state_d = ST_OFF;       // disable
                else if (!differ) state_d = ST_IDLE;      // revert
                else if (tick_i)  state_d = ST_COUNT;     // first tick
            end
            ST_COUNT: begin
                if (!en_i)         state_d = ST_OFF;      // disable
                else if (!differ)  state_d = ST_IDLE;     // revert
                else if (accept_o) state_d = ST_IDLE;     // accept
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (state_q == ST_COUNT && state_d == ST_COUNT)
            cnt_q <= cnt_q + {{(CW-1){1'b0}}, tick_i};
        else
            cnt_q <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        level_q <= 1'b0;
        else if (accept_o) level_q <= in_i;
    end

    assign level_o = level_q;

    AST_LEVEL_FROM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> ($past(state_q) == ST_COUNT))
        else $error("level moved outside counting state"); // R2

    AST_ALIGN_BEFORE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && $past(state_q) != ST_COUNT) |-> ($past(state_q) == ST_ALIGN))
        else $error("counting began without alignment"); // R3

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == ST_OFF))
        else $error("disabled channel left off state"); // R8

    AST_OFF_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> (level_q == $past(level_q)))
        else $error("level changed while off"); // R8

endmodule

// File: rtl/msdb_regs.sv
module msdb_regs
    import msdb_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int CW      = 12,
    parameter int DW      = 16,
    parameter int AW      = 4,
    parameter int LEN_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic [AW-1:0]     rd_addr_i,
    input  logic [NCH-1:0]    accept_i,
    input  logic [NCH-1:0]    in_sync_i,
    input  logic [NCH-1:0]    level_i,
    output logic [NCH-1:0]    en_o,
    output logic [NCH-1:0]    pol_o,
    output logic [NCH*CW-1:0] len_o,
    output logic [NCH-1:0]    pend_o,
    output logic [DW-1:0]     rd_data_o
);

    localparam logic [AW-1:0] A_EN   = AW'(REG_EN);
    localparam logic [AW-1:0] A_POL  = AW'(REG_POL);
    localparam logic [AW-1:0] A_PEND = AW'(REG_PEND);
    localparam logic [AW-1:0] A_LVL  = AW'(REG_LVL);

    logic [NCH-1:0] en_q, pol_q, pend_q;
    logic [NCH-1:0] set_vec, clr_vec;
    logic [CW-1:0]  len_q [NCH];
    logic           unused_hi;

    assign unused_hi = ^wr_data_i[DW-1:CW];

    assign set_vec = accept_i & ~(in_sync_i ^ pol_q);
    assign clr_vec = (wr_en_i && wr_addr_i == A_PEND) ? wr_data_i[NCH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            pend_q <= '0;
        end else begin
            if (wr_en_i && wr_addr_i == A_EN)  en_q  <= wr_data_i[NCH-1:0];
            if (wr_en_i && wr_addr_i == A_POL) pol_q <= wr_data_i[NCH-1:0];
            pend_q <= (pend_q & ~clr_vec) | set_vec;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_len
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                len_q[g] <= CW'(LEN_RST);
            else if (wr_en_i && wr_addr_i == AW'(REG_LEN0 + g))
                len_q[g] <= wr_data_i[CW-1:0];
        end
        assign len_o[g*CW +: CW] = len_q[g];
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == A_EN)   rd_data_o = DW'(en_q);
        if (rd_addr_i == A_POL)  rd_data_o = DW'(pol_q);
        if (rd_addr_i == A_PEND) rd_data_o = DW'(pend_q);
        if (rd_addr_i == A_LVL)  rd_data_o = DW'(level_i);
        for (int i = 0; i < NCH; i++)
            if (rd_addr_i == AW'(REG_LEN0 + i)) rd_data_o = DW'(len_q[i]);
    end

    assign en_o   = en_q;
    assign pol_o  = pol_q;
    assign pend_o = pend_q;

    AST_PEND_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q)) != '0) |-> ($past(accept_i) != '0))
        else $error("pending set without an accept"); // R5

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_PEND && set_vec == '0)
        |=> ((pend_q & $past(wr_data_i[NCH-1:0])) == '0))
        else $error("write-one did not clear pending"); // R6

endmodule

// File: rtl/msdb_top.sv
module msdb_top #(
    parameter int NCH     = 8,
    parameter int CW      = 12,
    parameter int DW      = 16,
    parameter int AW      = 4,
    parameter int MAX_MS  = 4000,
    parameter int LEN_RST = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ms_tick,
    input  logic [NCH-1:0] in_pins,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    output logic [NCH-1:0] level_o,
    output logic           irq,
    output logic           cnt_clk_en
);

    logic [NCH-1:0]    in_sync;
    logic [NCH-1:0]    en_w, pol_w, pend_w;
    logic [NCH-1:0]    accept_w, busy_w, level_w;
    logic [NCH*CW-1:0] len_w;
    logic              gated_tick;
    logic              unused_pol;

    assign unused_pol = ^pol_w;

    msdb_sync #(.N(NCH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (in_pins),
        .sync_o  (in_sync)
    );

    msdb_regs #(
        .NCH(NCH), .CW(CW), .DW(DW), .AW(AW), .LEN_RST(LEN_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .accept_i  (accept_w),
        .in_sync_i (in_sync),
        .level_i   (level_w),
        .en_o      (en_w),
        .pol_o     (pol_w),
        .len_o     (len_w),
        .pend_o    (pend_w),
        .rd_data_o (rd_data)
    );

    // The millisecond time base reaches the counters only while requested.
    assign gated_tick = ms_tick & cnt_clk_en;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        msdb_chan #(.CW(CW), .MAX_MS(MAX_MS)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (en_w[g]),
            .tick_i   (gated_tick),
            .in_i     (in_sync[g]),
            .len_i    (len_w[g*CW +: CW]),
            .level_o  (level_w[g]),
            .accept_o (accept_w[g]),
            .busy_o   (busy_w[g])
        );
    end

    assign level_o    = level_w;
    assign irq        = |(pend_w & en_w);
    assign cnt_clk_en = |busy_w;

endmodule

// File: tb/sim_msdb_top.sv
module sim_msdb_top;

    localparam int NCH = 8;
    localparam int P   = 10;   // cycles per millisecond tick

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ms_tick = 1'b0;
    logic [NCH-1:0] in_pins = '0;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_addr = '0;
    logic [15:0]    wr_data = '0;
    logic [3:0]     rd_addr = '0;
    logic [15:0]    rd_data;
    logic [NCH-1:0] level_o;
    logic           irq;
    logic           cnt_clk_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int exp_q[$];
    logic [NCH-1:0] prev_lvl = '0;

    always #5 clk = ~clk;

    msdb_top u0 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .in_pins(in_pins),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .level_o(level_o), .irq(irq), .cnt_clk_en(cnt_clk_en)
    );

    initial begin
        forever begin
            repeat (P-1) @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: pushes the expected accepted level, then moves the pin.
    task automatic drive(input int ch, input logic val, input bit expect_evt);
        if (expect_evt) exp_q.push_back(ch*2 + int'(val));
        @(negedge clk);
        in_pins[ch] = val;
    endtask

    // Monitor: every accepted level change must match the queue front.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                if (level_o[i] !== prev_lvl[i]) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R2/R3: unexpected change ch=%0d actual=%0d expected=none", i, level_o[i]);
                    end else begin
                        int item;
                        item = exp_q.pop_front();
                        if (item != i*2 + int'(level_o[i])) begin
                            errors++;
                            $display("FAIL R2: event actual=%0d expected=%0d", i*2 + int'(level_o[i]), item);
                        end
                    end
                end
            end
            prev_lvl = level_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        check("R1 level", 32'(level_o), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 clk_en", 32'(cnt_clk_en), 0);
        rd(4'd0, d); check("R1 enable", 32'(d), 0);
        rd(4'd2, d); check("R1 pending", 32'(d), 0);
        rd(4'd8, d); check("R1 length", 32'(d), 1);

        // R10 configuration and readback
        wr(4'd0, 16'h00FF);
        wr(4'd1, 16'h00FF);
        wr(4'd8, 16'd3);
        wr(4'd9, 16'd0);
        wr(4'd10, 16'd4095);
        wr(4'd12, 16'd2);
        rd(4'd0, d);  check("R10 enable readback", 32'(d), 32'h00FF);
        rd(4'd1, d);  check("R10 polarity readback", 32'(d), 32'h00FF);
        rd(4'd10, d); check("R10/R4 raw length readback", 32'(d), 4095);

        // R2 / R9: channel 0 rising, 3 ms
        drive(0, 1'b1, 1'b1);
        wait_cyc(3*P);
        check("R2 not before window", 32'(level_o[0]), 0);
        check("R9 clk_en while counting", 32'(cnt_clk_en), 1);
        wait_cyc(P + 5);
        check("R2 accepted", 32'(level_o[0]), 1);
        check("R9 clk_en idle", 32'(cnt_clk_en), 0);
        check("R5 irq on rise", 32'(irq), 1);
        rd(4'd3, d); check("R10 level register", 32'(d[0]), 1);

        // R6 write-one-to-clear
        wr(4'd2, 16'h0000);
        rd(4'd2, d); check("R6 zero write keeps pending", 32'(d[0]), 1);
        wr(4'd2, 16'h0001);
        rd(4'd2, d); check("R6 one write clears", 32'(d[0]), 0);
        check("R6 irq after clear", 32'(irq), 0);

        // R5 falling accept with rising polarity sets nothing
        drive(0, 1'b0, 1'b1);
        wait_cyc(4*P + 5);
        check("R5 falling level", 32'(level_o[0]), 0);
        rd(4'd2, d); check("R5 no pending on fall", 32'(d[0]), 0);

        // R3 short glitch ignored
        drive(0, 1'b1, 1'b0);
        wait_cyc(P - 3);
        drive(0, 1'b0, 1'b0);
        wait_cyc(4*P);
        check("R3 glitch level", 32'(level_o[0]), 0);
        rd(4'd2, d); check("R3 glitch pending", 32'(d[0]), 0);

        // R3 revert restarts the window
        drive(0, 1'b1, 1'b0);
        wait_cyc(2*P);
        drive(0, 1'b0, 1'b0);
        wait_cyc(3);
        drive(0, 1'b1, 1'b1);
        wait_cyc(3*P);
        check("R3 restart not early", 32'(level_o[0]), 0);
        wait_cyc(P + 5);
        check("R3 restart accepted", 32'(level_o[0]), 1);
        wr(4'd2, 16'h0001);

        // R4 length 0 acts as 1 ms
        drive(1, 1'b1, 1'b1);
        wait_cyc(P);
        check("R4 zero length not instant", 32'(level_o[1]), 0);
        wait_cyc(P + 5);
        check("R4 zero length as 1 ms", 32'(level_o[1]), 1);

        // R7 enable masks irq, pending kept
        check("R7 irq with pending", 32'(irq), 1);
        wr(4'd0, 16'h00FD);
        check("R7 irq masked", 32'(irq), 0);
        rd(4'd2, d); check("R7 pending kept", 32'(d[1]), 1);
        wr(4'd0, 16'h00FF);
        check("R7 irq unmasked", 32'(irq), 1);
        wr(4'd2, 16'h00FF);

        // R4 clamp: 4095 acts as 4000 ms
        drive(2, 1'b1, 1'b1);
        wait_cyc(4000*P);
        check("R4 clamp not early", 32'(level_o[2]), 0);
        wait_cyc(P + 5);
        check("R4 clamp at 4000", 32'(level_o[2]), 1);
        wr(4'd2, 16'h00FF);

        // R8 disabled channel ignores input
        wr(4'd0, 16'h00EF);
        drive(4, 1'b1, 1'b0);
        wait_cyc(5*P);
        check("R8 level frozen", 32'(level_o[4]), 0);
        check("R8 clk_en low", 32'(cnt_clk_en), 0);
        rd(4'd2, d); check("R8 no pending", 32'(d[4]), 0);
        exp_q.push_back(4*2 + 1);
        wr(4'd0, 16'h00FF);
        wait_cyc(2*P);
        check("R8 enable starts window", 32'(level_o[4]), 0);
        wait_cyc(P + 5);
        check("R8 accepted after enable", 32'(level_o[4]), 1);

        // R6 sticky and re-arm
        drive(4, 1'b0, 1'b1);
        wait_cyc(3*P + 5);
        rd(4'd2, d); check("R6 sticky pending", 32'(d[4]), 1);
        wr(4'd2, 16'h0010);
        check("R6 irq after clear", 32'(irq), 0);
        drive(4, 1'b1, 1'b1);
        wait_cyc(3*P + 5);
        rd(4'd2, d); check("R6 re-armed fires", 32'(d[4]), 1);
        check("R6 irq again", 32'(irq), 1);

        wait_cyc(4);
        check("R2 scoreboard drained", 32'(exp_q.size()), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule